// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects up to eight interrupt request lines, resolves them by fixed priority and signals the processor on a single interrupt output. The processor answers with an acknowledge pulse and receives an 8-bit vector. The vector is formed from a programmed base in its upper five bits and the winning line number in its lower three bits.

Software drives an 8-bit write port. A select bit chooses between the command register and the data register. A command write with bit 4 set begins an initialization sequence of up to four words. That sequence sets the vector base, the trigger style and two optional service modes:
- Auto end-of-interrupt retires an interrupt at acknowledge time.
- Special nesting lets a line interrupt its own handler.

After initialization, data writes load the mask, and a command write of 0x20 retires the highest-priority interrupt in service. Each retirement pulses an output that names the line, so a level source can sample its line again.

Top module: `pic_core`

## Requirements
- R1: After reset the block is uninitialized. While `ready_o` is low, `int_o` stays low, and an acknowledge produces no vector and no `vec_vld_o` pulse.
- R2: A command write (`a0_i`=0) with bit 4 set starts initialization and clears the mask, request and in-service state. In that word, bit 0 set means a fourth word follows, bit 1 clear selects cascade, and bit 3 set selects level triggering (clear selects edge).
- R3: The data writes after the start word are taken in order as base, cascade word, then mode word. The cascade word is expected only when cascade was selected, and its value has no effect. The mode word is expected only when bit 0 was set, and without it both modes are off. `ready_o` rises after the final expected word.
- R4: In the mode word, bit 1 enables auto end-of-interrupt and bit 4 enables special nesting. These are reported on `aeoi_o` and `sfnm_o`.
- R5: On an acknowledge while `int_o` is high, `vec_o` = {base[7:3], line} and `vec_vld_o` pulses in the following cycle. Base 0x08 with line 1 gives 0x09.
- R6: In edge mode, a rising edge on a line latches its request. `int_o` rises in the cycle after the edge. After acknowledge, `int_o` drops and the same request is not presented again.
- R7: Line 0 has the highest priority. A request is presented only if no line of equal or higher priority is in service.
- R8: After initialization, a data write loads the mask (bit n masks line n). A masked request is held but not presented, and is presented once unmasked.
- R9: A command write of 0x20 after initialization clears the highest-priority in-service bit, and in the following cycle pulses `eoi_o` with that line on `eoi_line_o`.
- R10: With auto end-of-interrupt, an acknowledge sets no in-service bit and pulses `eoi_o` with the acknowledged line in the following cycle.
- R11: With special nesting, a new request on a line already in service is presented.
- R12: In level mode, the request follows the line level. A line still high after its end-of-interrupt is presented again, and a line that goes low is withdrawn.
- R13: An acknowledge while `int_o` is low changes no state and produces no `vec_vld_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| a0_i | input | 1 | 0 selects the command register, 1 selects the data register |
| wdata_i | input | 8 | Write data |
| irq_i | input | 8 | Interrupt request lines |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledged interrupt |
| vec_vld_o | output | 1 | One-cycle pulse marking a new vector |
| eoi_o | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_line_o | output | 3 | Line retired by the end-of-interrupt |
| ready_o | output | 1 | Initialization complete |
| aeoi_o | output | 1 | Auto end-of-interrupt enabled |
| sfnm_o | output | 1 | Special nesting enabled |

## Verification
Register writes take effect at the clock edge that samples them, so the bench checks `ready_o`, the mode flags and the mask effect in the cycle right after each write. A request edge is latched at the next edge and `int_o` is due one cycle after the line changes. `vec_vld_o`, `vec_o` and `eoi_o` are registered, so they are due in the cycle after the acknowledge or end-of-interrupt edge. The bench drives inputs on the falling clock edge and samples on the following falling edge, which lands every check in exactly that cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NLINES = 8;
  localparam int unsigned LW     = $clog2(NLINES);
  localparam int unsigned DW     = 8;
  localparam logic [DW-1:0] OCW_EOI = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } init_st_e;
endpackage

// File: rtl/pic_init_ctl.sv
module pic_init_ctl
  import pic_pkg::*;
#(
  parameter int unsigned BW = DW - LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [BW-1:0] base_o,
  output logic          aeoi_o,
  output logic          sfnm_o,
  output logic          level_o,
  output logic          start_o,
  output logic          mask_wr_o,
  output logic          eoi_cmd_o
);
  init_st_e st_q;
  logic need_mode_q, casc_q;
  logic dat_wr;

  assign start_o   = wr_i && !a0_i && wdata_i[4];
  assign dat_wr    = wr_i && a0_i;
  assign ready_o   = (st_q == ST_RUN);
  assign mask_wr_o = dat_wr && ready_o;
  assign eoi_cmd_o = wr_i && !a0_i && ready_o && (wdata_i == OCW_EOI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      need_mode_q <= 1'b0;
      casc_q      <= 1'b0;
      level_o     <= 1'b0;
      aeoi_o      <= 1'b0;
      sfnm_o      <= 1'b0;
      base_o      <= '0;
    end else if (start_o) begin
      st_q        <= ST_BASE;
      need_mode_q <= wdata_i[0];
      casc_q      <= !wdata_i[1];
      level_o     <= wdata_i[3];
      aeoi_o      <= 1'b0;
      sfnm_o      <= 1'b0;
    end else if (dat_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base_o <= wdata_i[DW-1:LW];
          st_q   <= casc_q ? ST_CASC : (need_mode_q ? ST_MODE : ST_RUN);
        end
        ST_CASC: st_q <= need_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: begin
          aeoi_o <= wdata_i[1];
          sfnm_o <= wdata_i[4];
          st_q   <= ST_RUN;
        end
        default: st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NLINES-1:0] irq_i,
  input  logic              inta_i,
  output logic              int_o,
  output logic [DW-1:0]     vec_o,
  output logic              vec_vld_o,
  output logic              eoi_o,
  output logic [LW-1:0]     eoi_line_o,
  output logic              ready_o,
  output logic              aeoi_o,
  output logic              sfnm_o
);
  localparam int unsigned BW = DW - LW;

  logic [BW-1:0]     base;
  logic              level, start, mask_wr, eoi_cmd;
  logic [NLINES-1:0] irr_q, isr_q, imr_q, prev_q;
  logic [NLINES-1:0] irr_d, isr_d, pend;
  logic              pend_any, isr_any, ack;
  logic [LW-1:0]     pend_idx, isr_idx;

  pic_init_ctl #(.BW(BW)) u_init (
    .clk_i, .rst_ni, .wr_i, .a0_i, .wdata_i,
    .ready_o, .base_o(base), .aeoi_o, .sfnm_o, .level_o(level),
    .start_o(start), .mask_wr_o(mask_wr), .eoi_cmd_o(eoi_cmd)
  );

  assign pend = irr_q & ~imr_q;

  pic_prio #(.N(NLINES)) u_pend_prio (.req_i(pend),  .any_o(pend_any), .idx_o(pend_idx));
  pic_prio #(.N(NLINES)) u_isr_prio  (.req_i(isr_q), .any_o(isr_any),  .idx_o(isr_idx));

  assign int_o = ready_o && pend_any &&
                 (!isr_any || (pend_idx < isr_idx) || (sfnm_o && pend_idx == isr_idx));
  assign ack   = inta_i && int_o;

  always_comb begin
    if (level) begin
      irr_d = irq_i;
    end else begin
      irr_d = irr_q;
      if (ack) irr_d[pend_idx] = 1'b0;
      irr_d = irr_d | (irq_i & ~prev_q);
    end
    if (start) irr_d = '0;

    isr_d = isr_q;
    if (eoi_cmd && isr_any) isr_d[isr_idx] = 1'b0;
    if (ack && !aeoi_o)     isr_d[pend_idx] = 1'b1;
    if (start)              isr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q      <= '0;
      isr_q      <= '0;
      imr_q      <= '0;
      prev_q     <= '0;
      vec_o      <= '0;
      vec_vld_o  <= 1'b0;
      eoi_o      <= 1'b0;
      eoi_line_o <= '0;
    end else begin
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      prev_q    <= irq_i;
      vec_vld_o <= ack;
      if (ack) vec_o <= {base, pend_idx};
      if (start)        imr_q <= '0;
      else if (mask_wr) imr_q <= wdata_i;
      eoi_o <= (ack && aeoi_o) || (eoi_cmd && isr_any);
      if (ack && aeoi_o)          eoi_line_o <= pend_idx;
      else if (eoi_cmd && isr_any) eoi_line_o <= isr_idx;
    end
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
  import pic_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          a0_i,
  input logic [DW-1:0] wdata_i,
  input logic          inta_i,
  input logic          int_o,
  input logic          vec_vld_o,
  input logic          eoi_o,
  input logic          aeoi_o,
  input logic          ready_o
);
  assert_int_needs_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !int_o);

  assert_ack_gives_vec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o) |=> vec_vld_o);

  assert_vec_needs_ack_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(inta_i && int_o));

  assert_auto_eoi_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && aeoi_o) |=> eoi_o);

  assert_eoi_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> ($past(inta_i && int_o && aeoi_o) ||
               $past(wr_i && !a0_i && ready_o && wdata_i == OCW_EOI)));
endmodule

bind pic_core pic_core_chk u_chk (
  .clk_i, .rst_ni, .wr_i, .a0_i, .wdata_i, .inta_i,
  .int_o, .vec_vld_o, .eoi_o, .aeoi_o, .ready_o
);

// File: tb/tb_pic_core.sv
module tb_pic_core;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_i = 1'b0, a0_i = 1'b0, inta_i = 1'b0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic       int_o, vec_vld_o, eoi_o, ready_o, aeoi_o, sfnm_o;
  logic [7:0] vec_o;
  logic [2:0] eoi_line_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pic_core dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit a0, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1; a0_i = a0; wdata_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic ack();
    @(negedge clk_i); inta_i = 1;
    @(negedge clk_i); inta_i = 0;
  endtask

  task automatic set_irq(input int n, input bit v);
    @(negedge clk_i); irq_i[n] = v;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 ready", ready_o, 0);
    chk("R1 int", int_o, 0);
    set_irq(0, 1); set_irq(0, 0);
    chk("R1 int while uninit", int_o, 0);
    ack();
    chk("R1 no vec", vec_vld_o, 0);
  endtask

  task automatic t_init_aeoi();
    wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'hff);
    chk("R3 not ready before mode word", ready_o, 0);
    wr(1, 8'h13);
    chk("R3 ready", ready_o, 1);
    chk("R4 aeoi", aeoi_o, 1);
    chk("R4 sfnm", sfnm_o, 1);
    set_irq(1, 1);
    chk("R6 int on edge", int_o, 1);
    ack();
    chk("R5 vld", vec_vld_o, 1);
    chk("R5 vec 0x09", vec_o, 8'h09);
    chk("R10 eoi", eoi_o, 1);
    chk("R10 eoi line", eoi_line_o, 1);
    chk("R6 int drops", int_o, 0);
    @(negedge clk_i);
    chk("R6 not presented twice", int_o, 0);
    set_irq(1, 0);
  endtask

  task automatic t_prio_eoi();
    wr(0, 8'h12); wr(1, 8'h20);
    chk("R3 ready without cascade/mode", ready_o, 1);
    chk("R3 aeoi off", aeoi_o, 0);
    chk("R3 sfnm off", sfnm_o, 0);
    ack();
    chk("R13 ack ignored", vec_vld_o, 0);
    set_irq(5, 1); set_irq(5, 0);
    ack();
    chk("R5 vec 0x25", vec_o, 8'h25);
    chk("R10 no eoi without auto", eoi_o, 0);
    set_irq(6, 1); set_irq(6, 0);
    chk("R7 lower blocked", int_o, 0);
    set_irq(2, 1); set_irq(2, 0);
    chk("R7 higher presented", int_o, 1);
    ack();
    chk("R7 vec 0x22", vec_o, 8'h22);
    wr(0, 8'h20);
    chk("R9 eoi", eoi_o, 1);
    chk("R9 eoi line 2", eoi_line_o, 2);
    chk("R7 still blocked by 5", int_o, 0);
    wr(0, 8'h20);
    chk("R9 eoi line 5", eoi_line_o, 5);
    chk("R7 line 6 presented", int_o, 1);
    ack();
    chk("R5 vec 0x26", vec_o, 8'h26);
    wr(0, 8'h20);
    chk("R9 eoi line 6", eoi_line_o, 6);
  endtask

  task automatic t_mask();
    wr(1, 8'h01);
    set_irq(0, 1); set_irq(0, 0);
    chk("R8 masked", int_o, 0);
    wr(1, 8'h00);
    chk("R8 unmasked", int_o, 1);
    ack();
    chk("R8 vec 0x20", vec_o, 8'h20);
    wr(0, 8'h20);
  endtask

  task automatic t_sfnm();
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h10);
    chk("R4 sfnm only", {aeoi_o, sfnm_o}, 2'b01);
    set_irq(3, 1); set_irq(3, 0);
    ack();
    chk("R5 vec 0x43", vec_o, 8'h43);
    set_irq(3, 1); set_irq(3, 0);
    chk("R11 nest same line", int_o, 1);
    ack();
    chk("R11 vld", vec_vld_o, 1);
    wr(0, 8'h20); wr(0, 8'h20);
  endtask

  task automatic t_level();
    wr(0, 8'h19); wr(1, 8'h10); wr(1, 8'h00); wr(1, 8'h01);
    set_irq(4, 1);
    chk("R12 level int", int_o, 1);
    ack();
    chk("R12 vec 0x14", vec_o, 8'h14);
    chk("R12 blocked in service", int_o, 0);
    wr(0, 8'h20);
    chk("R12 re-presented", int_o, 1);
    set_irq(4, 0);
    chk("R12 withdrawn", int_o, 0);
    wr(0, 8'h11);
    chk("R2 restart clears ready", ready_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_init_aeoi();
    t_prio_eoi();
    t_mask();
    t_sfnm();
    t_level();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule